// File: doc/BRIEF.md
# Searchable Store Buffer

This block sits between a processor and its first-level data cache and holds stores that have been accepted from the processor but not yet written into the cache. Each entry is one word address with one data word, and entries stay in the order they arrived. A store is accepted on the enqueue port whenever there is room. The cache array itself is not touched at acceptance time.

A load presents its address on the search port. In the same cycle the block compares that address with every valid entry and returns the value of the youngest matching store. The load path uses a buffer hit in place of whatever the cache returns. On a buffer miss the cache result stands. The drain port shows the oldest entry to the cache, which retires it by accepting it. A drain-enable input lets the cache stop retirement while it handles a miss or serves a processor request.

The address width, data width and depth are parameters. Addresses are compared at word granularity, so the two byte-offset bits play no part in matching.

Top module: `stq_search_buffer`

## Requirements
- R1: A synchronous active-high reset empties the buffer. After reset `head_valid` and `srch_hit` are 0 and `enq_ready` is 1.
- R2: With `DEPTH` entries held and no retirement in the same cycle, `enq_ready` is 0 and an offered store is not taken. The buffer then keeps exactly the stores it already held.
- R3: The search result depends only on the current `srch_addr` and the stored entries, and it appears in the same cycle with no added clock cycle.
- R4: When several valid entries match, `srch_data` is the data of the most recently enqueued matching entry.
- R5: When no valid entry matches, `srch_hit` is 0 and `srch_data` is all zeros.
- R6: Entries retire oldest first. `head_addr`/`head_data` show the oldest entry and stay stable until `head_accept` takes it, at which point the next oldest entry is shown.
- R7: While `drain_en` is 0, `head_valid` is 0 and no entry is removed, whatever the value of `head_accept`.
- R8: When the buffer is full and the head is accepted in a cycle, `enq_ready` is 1 in that cycle. An enqueue and a dequeue in that cycle both take effect and the occupancy stays at `DEPTH`.
- R9: A search does not see a store enqueued in the same cycle. A search does still see an entry that is retiring in the same cycle.
- R10: Matching uses the address with bits [1:0] dropped. Two addresses that differ only in those bits match, and addresses in different words do not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| enq_valid | input | 1 | Processor offers a store |
| enq_ready | output | 1 | Buffer can take a store this cycle |
| enq_addr | input | ADDR_W | Byte address of the offered store |
| enq_data | input | DATA_W | Data word of the offered store |
| srch_addr | input | ADDR_W | Byte address of the load being looked up |
| srch_hit | output | 1 | A valid entry matches the load word |
| srch_data | output | DATA_W | Data of the youngest matching entry, zero on a miss |
| drain_en | input | 1 | Cache allows retirement this cycle |
| head_valid | output | 1 | Oldest entry is offered to the cache |
| head_addr | output | ADDR_W | Address of the oldest entry |
| head_data | output | DATA_W | Data of the oldest entry |
| head_accept | input | 1 | Cache takes the offered oldest entry |

## Verification
The bench targets the case where the same word has been written more than once. A design that picks the oldest match, or the match in the lowest slot, returns stale data after the write pointer wraps. It also searches on the same cycle as an enqueue and on the same cycle as a retire. Here a design that forwards the incoming store, or hides the leaving store, gives the wrong hit flag. It fills the buffer and then enqueues and retires together. A design that clears the valid bit after setting it would lose the new store, and one that gates readiness on fullness alone would stall. It also holds `drain_en` low with `head_accept` high, to catch a design that retires entries while the cache is busy.

// File: rtl/stq_pkg.sv
package stq_pkg;

    localparam int unsigned STQ_ADDR_W   = 32;
    localparam int unsigned STQ_DATA_W   = 32;
    localparam int unsigned STQ_DEPTH    = 4;
    // number of byte-select bits ignored when matching words
    localparam int unsigned STQ_BYTE_OFS = 2;

    // advance a circular slot index by one
    function automatic int unsigned stq_next(input int unsigned p, input int unsigned depth);
        return (p + 1 >= depth) ? 0 : p + 1;
    endfunction

    // slot holding the entry that is "age" places behind the oldest one
    function automatic int unsigned stq_slot_of(input int unsigned oldest,
                                                input int unsigned age,
                                                input int unsigned depth);
        int unsigned s;
        s = oldest + age;
        return (s >= depth) ? s - depth : s;
    endfunction

endpackage

// File: rtl/stq_ptr_ctrl.sv
module stq_ptr_ctrl #(
    parameter int unsigned DEPTH = 4,
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic             pop,
    output logic [PTR_W-1:0] rd_idx,
    output logic [PTR_W-1:0] wr_idx,
    output logic             full
);
    import stq_pkg::*;

    typedef struct packed {
        logic [PTR_W-1:0] rd;
        logic [PTR_W-1:0] wr;
        logic [CNT_W-1:0] cnt;
    } ptr_state_t;

    ptr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (push) begin
            st_d.wr = PTR_W'(stq_next(int'(st_q.wr), DEPTH));
        end
        if (pop) begin
            st_d.rd = PTR_W'(stq_next(int'(st_q.rd), DEPTH));
        end
        case ({push, pop})
            2'b10:   st_d.cnt = st_q.cnt + CNT_W'(1);
            2'b01:   st_d.cnt = st_q.cnt - CNT_W'(1);
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_idx = st_q.rd;
    assign wr_idx = st_q.wr;
    assign full   = (st_q.cnt == CNT_W'(DEPTH));

endmodule

// File: rtl/stq_slots.sv
module stq_slots #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned DEPTH  = 4,
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_en,
    input  logic [PTR_W-1:0]              wr_idx,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [DATA_W-1:0]             wr_data,
    input  logic                          clr_en,
    input  logic [PTR_W-1:0]              clr_idx,
    output logic [DEPTH-1:0]              slot_vld,
    output logic [DEPTH-1:0][ADDR_W-1:0]  slot_addr,
    output logic [DEPTH-1:0][DATA_W-1:0]  slot_data
);

    typedef struct packed {
        logic [DEPTH-1:0]             vld;
        logic [DEPTH-1:0][ADDR_W-1:0] addr;
        logic [DEPTH-1:0][DATA_W-1:0] data;
    } slot_state_t;

    slot_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // the clear goes first so that a write to the slot being freed
        // in the same cycle (full buffer, push and pop together) survives
        if (clr_en) begin
            st_d.vld[clr_idx] = 1'b0;
        end
        if (wr_en) begin
            st_d.vld[wr_idx]  = 1'b1;
            st_d.addr[wr_idx] = wr_addr;
            st_d.data[wr_idx] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign slot_vld  = st_q.vld;
    assign slot_addr = st_q.addr;
    assign slot_data = st_q.data;

endmodule

// File: rtl/stq_youngest_match.sv
module stq_youngest_match #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned DEPTH  = 4,
    parameter int unsigned OFS    = 2,
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic [DEPTH-1:0]              slot_vld,
    input  logic [DEPTH-1:0][ADDR_W-1:0]  slot_addr,
    input  logic [DEPTH-1:0][DATA_W-1:0]  slot_data,
    input  logic [PTR_W-1:0]              oldest_idx,
    input  logic [ADDR_W-1:0]             key_addr,
    output logic                          hit,
    output logic [DATA_W-1:0]             hit_data
);
    import stq_pkg::*;

    logic [DEPTH-1:0] eq;

    // one word comparator per slot
    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign eq[g] = slot_vld[g] &&
                       (slot_addr[g][ADDR_W-1:OFS] == key_addr[ADDR_W-1:OFS]);
    end

    // walk from oldest to youngest; a later match overrides an earlier one
    always_comb begin
        hit      = 1'b0;
        hit_data = '0;
        for (int unsigned age = 0; age < DEPTH; age++) begin
            int unsigned s;
            s = stq_slot_of(int'(oldest_idx), age, DEPTH);
            if (eq[s]) begin
                hit      = 1'b1;
                hit_data = slot_data[s];
            end
        end
    end

endmodule

// File: rtl/stq_search_buffer.sv
module stq_search_buffer #(
    parameter int unsigned ADDR_W = stq_pkg::STQ_ADDR_W,
    parameter int unsigned DATA_W = stq_pkg::STQ_DATA_W,
    parameter int unsigned DEPTH  = stq_pkg::STQ_DEPTH,
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enq_valid,
    output logic              enq_ready,
    input  logic [ADDR_W-1:0] enq_addr,
    input  logic [DATA_W-1:0] enq_data,
    input  logic [ADDR_W-1:0] srch_addr,
    output logic              srch_hit,
    output logic [DATA_W-1:0] srch_data,
    input  logic              drain_en,
    output logic              head_valid,
    output logic [ADDR_W-1:0] head_addr,
    output logic [DATA_W-1:0] head_data,
    input  logic              head_accept
);

    logic                         push, pop, full;
    logic [PTR_W-1:0]             rd_idx, wr_idx;
    logic [DEPTH-1:0]             slot_vld;
    logic [DEPTH-1:0][ADDR_W-1:0] slot_addr;
    logic [DEPTH-1:0][DATA_W-1:0] slot_data;

    assign head_valid = slot_vld[rd_idx] && drain_en;
    assign head_addr  = slot_addr[rd_idx];
    assign head_data  = slot_data[rd_idx];
    assign pop        = head_valid && head_accept;
    assign enq_ready  = !full || pop;
    assign push       = enq_valid && enq_ready;

    stq_ptr_ctrl #(.DEPTH(DEPTH)) ptr_i (
        .clk    (clk),
        .rst    (rst),
        .push   (push),
        .pop    (pop),
        .rd_idx (rd_idx),
        .wr_idx (wr_idx),
        .full   (full)
    );

    stq_slots #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) slots_i (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (push),
        .wr_idx    (wr_idx),
        .wr_addr   (enq_addr),
        .wr_data   (enq_data),
        .clr_en    (pop),
        .clr_idx   (rd_idx),
        .slot_vld  (slot_vld),
        .slot_addr (slot_addr),
        .slot_data (slot_data)
    );

    stq_youngest_match #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH),
        .OFS    (stq_pkg::STQ_BYTE_OFS)
    ) match_i (
        .slot_vld   (slot_vld),
        .slot_addr  (slot_addr),
        .slot_data  (slot_data),
        .oldest_idx (rd_idx),
        .key_addr   (srch_addr),
        .hit        (srch_hit),
        .hit_data   (srch_data)
    );

endmodule

// File: rtl/stq_search_buffer_chk.sv
module stq_search_buffer_chk #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned DEPTH  = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              enq_valid,
    input logic              enq_ready,
    input logic [ADDR_W-1:0] enq_addr,
    input logic [DATA_W-1:0] enq_data,
    input logic [ADDR_W-1:0] srch_addr,
    input logic              srch_hit,
    input logic [DATA_W-1:0] srch_data,
    input logic              drain_en,
    input logic              head_valid,
    input logic [ADDR_W-1:0] head_addr,
    input logic [DATA_W-1:0] head_data,
    input logic              head_accept
);

    int unsigned occ;
    logic        up, down;

    assign up   = enq_valid && enq_ready;
    assign down = head_valid && head_accept;

    always_ff @(posedge clk) begin
        if (rst) begin
            occ <= 0;
        end else begin
            occ <= occ + (up ? 1 : 0) - (down ? 1 : 0);
        end
    end

    assert_reset_empty_R1: assert property (@(posedge clk)
        rst |=> (!head_valid && !srch_hit && enq_ready));

    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (rst)
        occ <= DEPTH);

    assert_full_stall_R2: assert property (@(posedge clk) disable iff (rst)
        (occ == DEPTH && !down) |-> !enq_ready);

    assert_miss_zero_R5: assert property (@(posedge clk) disable iff (rst)
        !srch_hit |-> (srch_data == '0));

    assert_head_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (head_valid && !head_accept) |=>
            (!head_valid || ($stable(head_addr) && $stable(head_data))));

    assert_drain_gate_R7: assert property (@(posedge clk) disable iff (rst)
        !drain_en |-> !head_valid);

    assert_full_swap_R8: assert property (@(posedge clk) disable iff (rst)
        (occ == DEPTH && down) |-> enq_ready);

    assert_empty_no_head_R6: assert property (@(posedge clk) disable iff (rst)
        (occ == 0) |-> !head_valid);

endmodule

bind stq_search_buffer stq_search_buffer_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH)
) chk_i (.*);

// File: tb/stq_search_buffer_tb_top.sv
module stq_search_buffer_tb_top;

    localparam int unsigned ADDR_W   = 32;
    localparam int unsigned DATA_W   = 32;
    localparam int unsigned DEPTH    = 4;
    localparam time         CLK_PER  = 10ns;
    localparam int unsigned WD_LIMIT = 20000;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              enq_valid = 1'b0;
    logic              enq_ready;
    logic [ADDR_W-1:0] enq_addr = '0;
    logic [DATA_W-1:0] enq_data = '0;
    logic [ADDR_W-1:0] srch_addr = '0;
    logic              srch_hit;
    logic [DATA_W-1:0] srch_data;
    logic              drain_en = 1'b0;
    logic              head_valid;
    logic [ADDR_W-1:0] head_addr;
    logic [DATA_W-1:0] head_data;
    logic              head_accept = 1'b0;

    int unsigned n_checks = 0;
    int unsigned n_fail   = 0;
    int unsigned n_cyc    = 0;

    logic [ADDR_W-1:0] m_addr[$];
    logic [DATA_W-1:0] m_data[$];

    always #(CLK_PER / 2) clk = ~clk;

    stq_search_buffer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) dut_i (
        .clk (clk), .rst (rst),
        .enq_valid (enq_valid), .enq_ready (enq_ready),
        .enq_addr (enq_addr), .enq_data (enq_data),
        .srch_addr (srch_addr), .srch_hit (srch_hit), .srch_data (srch_data),
        .drain_en (drain_en), .head_valid (head_valid),
        .head_addr (head_addr), .head_data (head_data),
        .head_accept (head_accept)
    );

    task automatic check(input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    endtask

    // one clock: drive at the falling edge, compare combinational outputs
    // against the queue model, then let the rising edge update the model
    task automatic cycle(input string tag, input bit ev, input logic [ADDR_W-1:0] ea,
                         input logic [DATA_W-1:0] ed, input bit acc, input bit den,
                         input logic [ADDR_W-1:0] sa);
        bit                exp_hv, exp_rdy, exp_hit, do_pop, do_push;
        logic [DATA_W-1:0] exp_sd;
        enq_valid   = ev;
        enq_addr    = ea;
        enq_data    = ed;
        head_accept = acc;
        drain_en    = den;
        srch_addr   = sa;
        #1;
        exp_hv  = (m_addr.size() > 0) && den;
        do_pop  = exp_hv && acc;
        exp_rdy = (m_addr.size() < DEPTH) || do_pop;
        do_push = ev && exp_rdy;
        exp_hit = 1'b0;
        exp_sd  = '0;
        for (int i = 0; i < m_addr.size(); i++) begin
            if (m_addr[i][ADDR_W-1:2] == sa[ADDR_W-1:2]) begin
                exp_hit = 1'b1;
                exp_sd  = m_data[i];
            end
        end
        check(tag, "head_valid", 64'(head_valid), 64'(exp_hv));
        if (exp_hv) begin
            check(tag, "head_addr", 64'(head_addr), 64'(m_addr[0]));
            check(tag, "head_data", 64'(head_data), 64'(m_data[0]));
        end
        check(tag, "enq_ready", 64'(enq_ready), 64'(exp_rdy));
        check(tag, "srch_hit", 64'(srch_hit), 64'(exp_hit));
        check(tag, "srch_data", 64'(srch_data), 64'(exp_sd));
        @(posedge clk);
        if (do_pop) begin
            void'(m_addr.pop_front());
            void'(m_data.pop_front());
        end
        if (do_push) begin
            m_addr.push_back(ea);
            m_data.push_back(ed);
        end
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        enq_valid = 1'b0;
        head_accept = 1'b0;
        drain_en = 1'b0;
        @(posedge clk);
        m_addr.delete();
        m_data.delete();
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        cycle("R1", 0, '0, '0, 0, 1, 32'h0);
        cycle("R1", 1, 32'h40, 32'hA1, 0, 0, 32'h40);
        cycle("R1", 1, 32'h44, 32'hA2, 0, 0, 32'h40);
        do_reset();
        cycle("R1", 0, '0, '0, 1, 1, 32'h40);
    endtask

    task automatic t_fill_full();
        for (int i = 0; i < DEPTH + 2; i++) begin
            cycle("R2", 1, 32'h1000 + 32'(i * 4), 32'hB0 + 32'(i), 0, 0, 32'h1000);
        end
        cycle("R2", 0, '0, '0, 0, 0, 32'h1000 + 32'(DEPTH * 4));
        for (int i = 0; i < DEPTH; i++) cycle("R6", 0, '0, '0, 1, 1, 32'h0);
    endtask

    task automatic t_youngest();
        cycle("R4", 1, 32'h100, 32'hD1, 0, 0, 32'h100);
        cycle("R4", 1, 32'h200, 32'hD2, 0, 0, 32'h100);
        cycle("R4", 1, 32'h100, 32'hD3, 0, 0, 32'h100);
        cycle("R3", 0, '0, '0, 0, 0, 32'h100);
        cycle("R3", 0, '0, '0, 0, 0, 32'h200);
        cycle("R5", 0, '0, '0, 0, 0, 32'h300);
        cycle("R4", 0, '0, '0, 1, 1, 32'h100);
        cycle("R4", 1, 32'h100, 32'hD4, 1, 1, 32'h100);
        cycle("R4", 1, 32'h100, 32'hD5, 0, 0, 32'h100);
        cycle("R4", 0, '0, '0, 0, 0, 32'h100);
        for (int i = 0; i < 4; i++) cycle("R6", 0, '0, '0, 1, 1, 32'h100);
    endtask

    task automatic t_drain_block();
        cycle("R7", 1, 32'h500, 32'hE1, 1, 0, 32'h500);
        cycle("R7", 1, 32'h504, 32'hE2, 1, 0, 32'h500);
        cycle("R7", 0, '0, '0, 1, 0, 32'h500);
        cycle("R7", 0, '0, '0, 1, 0, 32'h504);
        cycle("R6", 0, '0, '0, 0, 1, 32'h500);
        cycle("R6", 0, '0, '0, 1, 1, 32'h500);
        cycle("R6", 0, '0, '0, 1, 1, 32'h504);
        cycle("R6", 0, '0, '0, 1, 1, 32'h504);
    endtask

    task automatic t_full_swap();
        for (int i = 0; i < DEPTH; i++) begin
            cycle("R8", 1, 32'h600 + 32'(i * 4), 32'hF0 + 32'(i), 0, 0, 32'h600);
        end
        cycle("R8", 1, 32'h700, 32'hF9, 1, 1, 32'h600);
        cycle("R8", 1, 32'h704, 32'hFA, 0, 1, 32'h700);
        cycle("R8", 0, '0, '0, 0, 0, 32'h700);
        for (int i = 0; i < DEPTH + 1; i++) cycle("R6", 0, '0, '0, 1, 1, 32'h700);
    endtask

    task automatic t_same_cycle();
        cycle("R9", 1, 32'h800, 32'hC1, 0, 0, 32'h800);
        cycle("R9", 0, '0, '0, 0, 0, 32'h800);
        cycle("R9", 0, '0, '0, 1, 1, 32'h800);
        cycle("R9", 0, '0, '0, 0, 1, 32'h800);
    endtask

    task automatic t_word();
        cycle("R10", 1, 32'h900, 32'h77, 0, 0, 32'h903);
        cycle("R10", 0, '0, '0, 0, 0, 32'h902);
        cycle("R10", 0, '0, '0, 0, 0, 32'h904);
        cycle("R10", 0, '0, '0, 0, 0, 32'h8FC);
        cycle("R10", 1, 32'h901, 32'h88, 0, 0, 32'h900);
        cycle("R10", 0, '0, '0, 0, 0, 32'h903);
        cycle("R6", 0, '0, '0, 1, 1, 32'h0);
        cycle("R6", 0, '0, '0, 1, 1, 32'h0);
    endtask

    task automatic t_random();
        for (int i = 0; i < 400; i++) begin
            logic [ADDR_W-1:0] a, s;
            a = 32'h2000 + 32'($urandom_range(0, 5) * 4) + 32'($urandom_range(0, 3));
            s = 32'h2000 + 32'($urandom_range(0, 6) * 4) + 32'($urandom_range(0, 3));
            cycle("R4", bit'($urandom_range(0, 1)), a, 32'($urandom),
                  bit'($urandom_range(0, 1)), ($urandom_range(0, 3) != 0), s);
        end
    endtask

    initial begin
        fork
            begin
                @(negedge clk);
                t_reset();
                t_fill_full();
                t_youngest();
                t_drain_block();
                t_full_swap();
                t_same_cycle();
                t_word();
                t_random();
                report();
                $finish;
            end
            begin
                while (n_cyc < WD_LIMIT) begin
                    @(posedge clk);
                    n_cyc++;
                end
                n_checks++;
                n_fail++;
                $display("FAIL watchdog run did not finish actual=%0d expected<%0d", n_cyc, WD_LIMIT);
                report();
                $finish;
            end
        join_any
    end

endmodule